// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory holding 128 bytes. A fast system clock oversamples the SCL and SDA bus lines. The block recognises start and stop conditions and receives 8-bit words, most significant bit first. It answers only to its own device address, whose upper nibble is fixed at binary 1010 and whose next three bits come from strap inputs. It acknowledges each accepted word by pulling SDA low during the ninth clock.

A master writes by sending a word address followed by one or more data bytes. The bytes are collected in a page buffer and written to the storage array during a self-timed write cycle, which starts when the master sends a stop. During that cycle the block ignores the bus entirely, so a master polls for completion by sending its device address until it is acknowledged. Reads come in three kinds: current-address reads, random reads (a dummy write that loads the address, then a repeated start) and sequential reads that continue for as long as the master acknowledges.

The storage is a register array with one synchronous read port and one write port. On the bus side, SDA is an open-drain line: the block only ever enables a low drive and never drives the line high.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the SDA drive enable is low and the block waits for a start condition.
- R2: A device address is accepted only when its bits 7..4 equal 1010 and its bits 3..1 equal `strap_i[2:0]`. Bit 0 selects read (1) or write (0). On a mismatch nothing is acknowledged until the next start.
- R3: In a write, the byte after the device address is the word address, of which bits 6..0 are used and bit 7 is ignored. That byte and every following data byte are acknowledged by a low SDA during the ninth SCL pulse.
- R4: Within a write, only the low three address bits advance after each data byte, so addresses wrap inside the same 8-byte page. A ninth byte overwrites the first byte written in that page.
- R5: A stop that ends a write holding at least one complete data byte starts a self-timed write cycle. While that cycle runs, nothing is acknowledged, not even the device address. Once it ends, the device address is acknowledged again.
- R6: A random read (write-mode device address, word address, repeated start, read-mode device address) returns the byte at the loaded word address.
- R7: In a read, the block sends the next byte, at an address advanced by one and wrapping from 127 to 0, for as long as the master acknowledges. After a ninth bit left high it stops driving SDA.
- R8: A current-address read returns the byte one past the last byte accessed. After a write, that address wraps within the page.
- R9: The SDA drive enable changes only while SCL is low. The block never drives SDA high.
- R10: A start in any state aborts the transaction in progress. Write data not followed by a stop is discarded, and no write cycle begins.
- R11: SCL and SDA each pass through a two-stage synchronizer and a three-sample majority filter, so a pulse lasting one system clock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Pin-strapped low bits of the device address |
| sda_oe_o | output | 1 | Drive-low enable for the open-drain SDA pad |

## Verification
Byte writes, over-length page writes that wrap inside a page, random reads, current-address reads and sequential reads are run against a behavioural memory model in the bench. Each one tests a different rule for how the address counter advances: it holds within the page on writes, it crosses pages and wraps at 127 on reads, and it sits one past the last access between transactions. A mismatched device address, polling while the write cycle is busy, and a write aborted by a repeated start all check that the block stays silent and leaves storage untouched. A one-clock glitch on SCL in the middle of a data byte shows that the input filter rejects it.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK
  } twi_state_e;
endpackage

// File: rtl/twi_deglitch.sv
module twi_deglitch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [2:0]             hist_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
      dout   <= (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) | (hist_q[1] & hist_q[2]);
    end
  end
endmodule

// File: rtl/twi_store.sv
module twi_store #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 500000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [7:0]               rdata,
  input  logic                     bw_en,
  input  logic [PAGE_W-1:0]        bw_idx,
  input  logic [7:0]               bw_data,
  input  logic                     buf_clear,
  input  logic                     commit_req,
  input  logic [ADDR_W-PAGE_W-1:0] commit_row,
  output logic                     busy,
  output logic                     mem_we
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [7:0]        mem_q  [DEPTH];
  logic [7:0]        page_q [PAGE];
  logic [PAGE-1:0]   valid_q;
  logic [CNT_W-1:0]  tcnt_q;
  logic [ROW_W-1:0]  row_q;
  logic              busy_q;
  logic [PAGE_W-1:0] cidx;
  logic [ADDR_W-1:0] waddr;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] = 8'h00;
  end

  assign cidx   = tcnt_q[PAGE_W-1:0];
  assign mem_we = busy_q && (tcnt_q < CNT_W'(PAGE)) && valid_q[cidx];
  assign waddr  = {row_q, cidx};
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      valid_q <= '0;
      tcnt_q  <= '0;
      row_q   <= '0;
    end else if (busy_q) begin
      tcnt_q <= tcnt_q + 1'b1;
      if (tcnt_q == CNT_W'(WR_CYCLES - 1)) begin
        busy_q  <= 1'b0;
        valid_q <= '0;
      end
    end else if (commit_req) begin
      busy_q <= 1'b1;
      tcnt_q <= '0;
      row_q  <= commit_row;
    end else if (buf_clear) begin
      valid_q <= '0;
    end else if (bw_en) begin
      valid_q[bw_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bw_en && !busy_q) page_q[bw_idx] <= bw_data;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[waddr] <= page_q[cidx];
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
#(
  parameter int         ADDR_W   = 7,
  parameter int         PAGE_W   = 3,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scl,
  input  logic                     sda,
  input  logic [2:0]               strap,
  input  logic                     busy,
  input  logic [7:0]               rdata,
  output logic [ADDR_W-1:0]        ptr,
  output logic                     bw_en,
  output logic [PAGE_W-1:0]        bw_idx,
  output logic [7:0]               bw_data,
  output logic                     buf_clear,
  output logic                     commit_req,
  output logic [ADDR_W-PAGE_W-1:0] commit_row,
  output logic                     sda_oe
);
  twi_state_e state_q, after_ack_q;
  logic       scl_q, sda_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, tx_q;
  logic       have_data_q, mack_q;
  logic       scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise   = scl & ~scl_q;
  assign scl_fall   = ~scl & scl_q;
  assign start_c    = scl & scl_q & sda_q & ~sda;
  assign stop_c     = scl & scl_q & ~sda_q & sda;
  assign commit_row = ptr[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      after_ack_q <= ST_IDLE;
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      cnt_q       <= '0;
      sh_q        <= '0;
      tx_q        <= '0;
      have_data_q <= 1'b0;
      mack_q      <= 1'b0;
      ptr         <= '0;
      bw_en       <= 1'b0;
      bw_idx      <= '0;
      bw_data     <= '0;
      buf_clear   <= 1'b0;
      commit_req  <= 1'b0;
      sda_oe      <= 1'b0;
    end else begin
      scl_q      <= scl;
      sda_q      <= sda;
      bw_en      <= 1'b0;
      buf_clear  <= 1'b0;
      commit_req <= 1'b0;
      if (busy) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else if (start_c) begin
        state_q     <= ST_DEV;
        cnt_q       <= '0;
        sda_oe      <= 1'b0;
        buf_clear   <= 1'b1;
        have_data_q <= 1'b0;
      end else if (stop_c) begin
        commit_req  <= have_data_q;
        have_data_q <= 1'b0;
        state_q     <= ST_IDLE;
        sda_oe      <= 1'b0;
      end else begin
        case (state_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && cnt_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (sh_q[7:4] == DEV_CODE && sh_q[3:1] == strap) begin
                  sda_oe      <= 1'b1;
                  state_q     <= ST_ACK;
                  after_ack_q <= sh_q[0] ? ST_TX : ST_WADDR;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_WADDR) begin
                ptr         <= sh_q[ADDR_W-1:0];
                sda_oe      <= 1'b1;
                state_q     <= ST_ACK;
                after_ack_q <= ST_WDATA;
              end else begin
                bw_en       <= 1'b1;
                bw_idx      <= ptr[PAGE_W-1:0];
                bw_data     <= sh_q;
                ptr         <= {ptr[ADDR_W-1:PAGE_W], PAGE_W'(ptr[PAGE_W-1:0] + 1'b1)};
                have_data_q <= 1'b1;
                sda_oe      <= 1'b1;
                state_q     <= ST_ACK;
                after_ack_q <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (after_ack_q == ST_TX) begin
                tx_q    <= rdata;
                ptr     <= ptr + 1'b1;
                sda_oe  <= ~rdata[7];
                state_q <= ST_TX;
              end else begin
                sda_oe  <= 1'b0;
                state_q <= after_ack_q;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt_q == 4'd7) begin
                sda_oe  <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                cnt_q  <= cnt_q + 1'b1;
                tx_q   <= {tx_q[6:0], 1'b0};
                sda_oe <= ~tx_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda;
            if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                tx_q    <= rdata;
                ptr     <= ptr + 1'b1;
                sda_oe  <= ~rdata[7];
                state_q <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int         ADDR_W      = 7,
  parameter int         PAGE_W      = 3,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         WR_CYCLES   = 500000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  logic [1:0]        raw, filt;
  logic              scl_f, sda_f;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rdata, bw_data;
  logic [PAGE_W-1:0] bw_idx;
  logic [ROW_W-1:0]  commit_row;
  logic              bw_en, buf_clear, commit_req, busy, mem_we;

  assign raw   = {sda_i, scl_i};
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  for (genvar g = 0; g < 2; g++) begin : g_line
    twi_deglitch #(.SYNC_STAGES(SYNC_STAGES)) u_dg (
      .clk(clk), .rst(rst), .din(raw[g]), .dout(filt[g])
    );
  end

  twi_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEV_CODE(DEV_CODE)) u_eng (
    .clk(clk), .rst(rst), .scl(scl_f), .sda(sda_f), .strap(strap_i),
    .busy(busy), .rdata(rdata), .ptr(ptr), .bw_en(bw_en), .bw_idx(bw_idx),
    .bw_data(bw_data), .buf_clear(buf_clear), .commit_req(commit_req),
    .commit_row(commit_row), .sda_oe(sda_oe_o)
  );

  twi_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk(clk), .rst(rst), .raddr(ptr), .rdata(rdata), .bw_en(bw_en),
    .bw_idx(bw_idx), .bw_data(bw_data), .buf_clear(buf_clear),
    .commit_req(commit_req), .commit_row(commit_row), .busy(busy),
    .mem_we(mem_we)
  );
endmodule

// File: rtl/twi_checks.sv
module twi_checks (
  input logic clk,
  input logic rst,
  input logic scl_f,
  input logic sda_oe,
  input logic busy,
  input logic mem_we,
  input logic commit_req
);
  // R9: drive enable only moves while the filtered clock is low
  a_r9_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f);

  // R5: silent on the bus during the write cycle
  a_r5_busy_silent: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);

  // R5: storage is written only inside the write cycle
  a_r5_write_in_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R5: a write cycle only follows a committing stop
  a_r5_cycle_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(commit_req));
endmodule

bind twi_mem_slave twi_checks u_chk (
  .clk(clk), .rst(rst), .scl_f(scl_f), .sda_oe(sda_oe_o),
  .busy(busy), .mem_we(mem_we), .commit_req(commit_req)
);

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
  localparam int         Q     = 15;
  localparam int         H     = 30;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic oe;
  logic sda_line;
  int   tests = 0, fails = 0, viol = 0, cycles = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;
  int   mem_m [128];
  int   ptr_m = 0;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~oe;

  twi_mem_slave #(.WR_CYCLES(2000)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(oe)
  );

  // per-clock monitor: R9 drive changes only with SCL low
  always @(negedge clk) begin
    if (!rst && oe !== oe_prev && scl) viol++;
    oe_prev <= oe;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_out(input logic b, input logic glitch);
    m_sda = b; wt(Q);
    if (glitch) begin scl = 1'b1; wt(1); scl = 1'b0; wt(2); end
    scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
  endtask

  task automatic bit_in(output logic b);
    m_sda = 1'b1; wt(Q); scl = 1'b1; wt(H/2);
    b = sda_line; wt(H/2); scl = 1'b0; wt(Q);
  endtask

  task automatic start_c();
    m_sda = 1'b1; wt(Q); scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); scl = 1'b0; wt(Q);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wt(Q); scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic glitch, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i], glitch && i == 4);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
    bit_out(~mack, 1'b0);
  endtask

  task automatic wait_ready(output int polls);
    logic a;
    polls = 0; a = 1'b0;
    while (!a && polls < 12) begin
      start_c(); send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a); stop_c();
      polls++;
    end
  endtask

  task automatic page_write(input int addr, input int n, input int first);
    logic a;
    start_c();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
    send_byte(8'(addr), 1'b0, a);
    ptr_m = addr & 8'h7F;
    for (int i = 0; i < n; i++) begin
      send_byte(8'(first + i), 1'b0, a);
      mem_m[ptr_m] = (first + i) & 8'hFF;
      ptr_m = (ptr_m & 8'h78) | ((ptr_m + 1) & 7);
    end
    stop_c();
  endtask

  task automatic rand_read(input int addr, input int n, input string req);
    logic a; logic [7:0] v;
    start_c();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
    send_byte(8'(addr), 1'b0, a);
    start_c();
    send_byte({4'b1010, STRAP, 1'b1}, 1'b0, a);
    check(a, req, 0, 1);
    ptr_m = addr & 8'h7F;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      check(int'(v) == mem_m[ptr_m], req, int'(v), mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) & 8'h7F;
    end
  endtask

  initial begin
    logic a; logic [7:0] v; int polls;
    for (int i = 0; i < 128; i++) mem_m[i] = 0;
    wt(10); rst = 1'b0; wt(20);
    check(oe == 1'b0, "R1 released after reset", int'(oe), 0);

    // R2: wrong strap bits, then a further byte stays unanswered
    start_c();
    send_byte({4'b1010, 3'b011, 1'b0}, 1'b0, a);
    check(!a, "R2 mismatched address", int'(a), 0);
    send_byte(8'h00, 1'b0, a);
    check(!a, "R2 ignored until start", int'(a), 0);
    stop_c();

    // R3 / R11: byte write with bit 7 of the word address set, SCL glitch in data
    start_c();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
    check(a, "R2 matching address", int'(a), 1);
    send_byte(8'h90, 1'b0, a);
    check(a, "R3 word address ack", int'(a), 1);
    send_byte(8'hA5, 1'b1, a);
    check(a, "R11 data ack through glitch", int'(a), 1);
    stop_c();
    mem_m[8'h10] = 8'hA5; ptr_m = 8'h11;

    // R5: busy poll
    start_c();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
    check(!a, "R5 no ack while busy", int'(a), 0);
    stop_c();
    wait_ready(polls);
    check(polls < 12, "R5 ack after cycle", polls, 11);

    rand_read(8'h10, 1, "R6 random read");
    stop_c();

    // R4: ten bytes from 0x1E wrap inside page 0x18..0x1F
    page_write(8'h1E, 10, 8'h30);
    wait_ready(polls);

    // R8: current read after wrapped write
    start_c();
    send_byte({4'b1010, STRAP, 1'b1}, 1'b0, a);
    recv_byte(1'b0, v);
    check(int'(v) == mem_m[ptr_m], "R8 current read", int'(v), mem_m[ptr_m]);
    check(int'(v) == 8'h32, "R4 page rollover", int'(v), 8'h32);
    stop_c();

    // R7: sequential read over the page, next byte 0x20 is zero
    rand_read(8'h18, 8, "R7 sequential");
    wt(10);
    check(oe == 1'b0, "R7 released after nack", int'(oe), 0);
    stop_c();

    // R7: wrap from 127 to 0
    page_write(8'h7E, 2, 8'hC1);
    wait_ready(polls);
    page_write(8'h00, 1, 8'h5A);
    wait_ready(polls);
    rand_read(8'h7E, 3, "R7 wrap 127 to 0");
    stop_c();

    // R10: aborted write is discarded
    page_write(8'h40, 1, 8'h22);
    wait_ready(polls);
    start_c();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
    send_byte(8'h40, 1'b0, a);
    send_byte(8'h33, 1'b0, a);
    start_c();
    stop_c();
    start_c();
    send_byte({4'b1010, STRAP, 1'b0}, 1'b0, a);
    check(a, "R10 no write cycle after abort", int'(a), 1);
    stop_c();
    rand_read(8'h40, 1, "R10 old data kept");
    stop_c();

    check(viol == 0, "R9 drive moves with SCL low", viol, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule